// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

A single timer channel that counts down by one on every prescaler tick while it is enabled. It holds a counter, a reload value and a control word, and software reaches all three through separate write strobes sharing one data bus, with continuous readback of each. When an enabled tick finds the counter at zero, the channel expires. Expiry happens on the underflow, not on reaching zero. At expiry the channel can raise a one-cycle interrupt pulse and set a sticky pending flag.

A restart control bit picks the mode. In periodic mode the counter refills from the reload register at expiry. In one-shot mode the channel stops itself at expiry. A load command bit in the control word copies the reload value into the counter at once. Address decoding, the prescaler and any chaining between channels sit outside this block.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `count_q`, `reload_q` and `ctrl_q` all read 0 and `irq` is low.
- R2: An enabled channel (control bit 0 set) decrements the counter by one on each `tick` cycle that has no write strobe. Without a tick, or while disabled, the counter holds.
- R3: When the counter holds N and the channel is enabled, expiry happens on the (N+1)th enabled tick, the one that finds the counter at zero.
- R4: At expiry with interrupt enable (control bit 3) set, the pending flag (control bit 4) is set and `irq` is high for the single following cycle. With bit 3 clear, `irq` stays low and the pending flag is unchanged.
- R5: At expiry with restart (control bit 1) set, the counter takes the reload value and counting continues.
- R6: At expiry with restart clear, the counter becomes all ones and the enable bit clears.
- R7: A control write with bit 4 set clears the pending flag. A control write with bit 4 clear keeps it. Nothing else clears it.
- R8: A control write with the load bit (bit 2) set copies the reload register into the counter. This load takes precedence over a counter write in the same cycle. Bits 2, 5, 6 and every bit above 6 of `ctrl_q` always read 0.
- R9: `wr_count` replaces the counter with `wdata`, and `wr_reload` replaces the reload register.
- R10: In a cycle where any write strobe is high, `tick` has no effect on the counter, the pending flag or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler tick, one cycle wide |
| wr_count | input | 1 | Write strobe for the counter |
| wr_reload | input | 1 | Write strobe for the reload register |
| wr_ctrl | input | 1 | Write strobe for the control word |
| wdata | input | W | Write data shared by the three strobes |
| count_q | output | W | Current counter value |
| reload_q | output | W | Reload register |
| ctrl_q | output | W | Control word: bit0 enable, bit1 restart, bit3 interrupt enable, bit4 pending |
| irq | output | 1 | One-cycle interrupt pulse at expiry |

## Verification
Two functions can fall in the same cycle: a prescaler tick and a register write. The bench provokes this by raising `tick` together with a reload write, a counter write or a control write. It does this both mid-count and while the counter sits at zero, where the tick would otherwise expire the channel. A reference model written behaviourally in the bench judges every cycle: the counter must follow the write, and no pending flag or interrupt pulse may appear from the suppressed tick.

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_count,
  input  logic         wr_reload,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count_q,
  output logic [W-1:0] reload_q,
  output logic [W-1:0] ctrl_q,
  output logic         irq
);
  logic [W-1:0] cnt, rld;
  logic en, rs, ie, pd, irq_q;

  wire wr_any = wr_count | wr_reload | wr_ctrl;
  wire load   = wr_ctrl & wdata[2];
  wire step   = tick & en & ~wr_any;
  wire expire = step & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rld   <= '0;
      en    <= 1'b0;
      rs    <= 1'b0;
      ie    <= 1'b0;
      pd    <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= expire & ie;
      if (wr_reload) rld <= wdata;
      if (wr_ctrl) begin
        en <= wdata[0];
        rs <= wdata[1];
        ie <= wdata[3];
        if (wdata[4]) pd <= 1'b0;
      end
      if (load)          cnt <= rld;
      else if (wr_count) cnt <= wdata;
      else if (expire) begin
        if (ie) pd <= 1'b1;
        if (rs) cnt <= rld;
        else begin
          cnt <= '1;
          en  <= 1'b0;
        end
      end else if (step) cnt <= cnt - 1'b1;
    end
  end

  assign count_q  = cnt;
  assign reload_q = rld;
  assign ctrl_q   = W'({pd, ie, 1'b0, rs, en});
  assign irq      = irq_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wr_count,
  input logic         wr_reload,
  input logic         wr_ctrl,
  input logic [W-1:0] wdata,
  input logic [W-1:0] count_q,
  input logic [W-1:0] ctrl_q,
  input logic         irq
);
  a_r1_reset_state: assert property (@(posedge clk) !rst_n |=> (count_q == '0 || !rst_n));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_count && !wr_ctrl) |=> $stable(count_q));

  a_r4_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[4]);

  a_r6_oneshot_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl_q[0] && !ctrl_q[1] && count_q == '0 && !wr_count && !wr_reload && !wr_ctrl)
    |=> (count_q == '1 && !ctrl_q[0]));

  a_r7_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] && !(wr_ctrl && wdata[4]) |=> ctrl_q[4]);

  a_r8_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[2] == 1'b0 && (ctrl_q >> 5) == '0);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_count && !(wr_ctrl && wdata[2])) |=> (count_q == $past(wdata) && !irq));
endmodule

bind tmr_channel tmr_channel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_count(wr_count),
  .wr_reload(wr_reload), .wr_ctrl(wr_ctrl), .wdata(wdata),
  .count_q(count_q), .ctrl_q(ctrl_q), .irq(irq)
);

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, wr_count = 0, wr_reload = 0, wr_ctrl = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] count_q, reload_q, ctrl_q;
  logic irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  tmr_channel #(.W(W)) u0 (.*);

  logic [W-1:0] m_cnt = '0, m_rld = '0;
  bit m_en = 0, m_rs = 0, m_ie = 0, m_pd = 0, m_irq = 0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_rld = '0; m_en = 0; m_rs = 0; m_ie = 0; m_pd = 0; m_irq = 0;
    end else begin
      logic [W-1:0] old_rld;
      bit writing;
      old_rld = m_rld;
      writing = wr_count || wr_reload || wr_ctrl;
      m_irq = 0;
      if (wr_reload) m_rld = wdata;
      if (wr_ctrl) begin
        m_en = wdata[0]; m_rs = wdata[1]; m_ie = wdata[3];
        if (wdata[4]) m_pd = 0;
      end
      if (wr_ctrl && wdata[2]) m_cnt = old_rld;
      else if (wr_count) m_cnt = wdata;
      else if (tick && m_en && !writing) begin
        if (m_cnt == 0) begin
          if (m_ie) begin m_pd = 1; m_irq = 1; end
          if (m_rs) m_cnt = old_rld;
          else begin m_cnt = '1; m_en = 0; end
        end else m_cnt = m_cnt - 1;
      end
    end
    #1;
    if (!done) begin
      chk({cur_req, " count"}, count_q, m_cnt);
      chk({cur_req, " reload"}, reload_q, m_rld);
      chk({cur_req, " ctrl"}, ctrl_q, W'({m_pd, m_ie, 1'b0, m_rs, m_en}));
      chk({cur_req, " irq"}, W'(irq), W'(m_irq));
    end
  end

  task automatic cyc(input bit t, input bit c, input bit r, input bit k, input logic [W-1:0] d);
    @(negedge clk);
    tick = t; wr_count = c; wr_reload = r; wr_ctrl = k; wdata = d;
    @(posedge clk); #2;
    tick = 0; wr_count = 0; wr_reload = 0; wr_ctrl = 0; wdata = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, '0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1";
    chk("R1 count", count_q, '0); chk("R1 ctrl", ctrl_q, '0); chk("R1 irq", W'(irq), '0);
    @(negedge clk); rst_n = 1;

    cur_req = "R9";
    cyc(0, 1, 0, 0, 32'd5);
    chk("R9 count write", count_q, 32'd5);
    cyc(0, 0, 1, 0, 32'hCAFE0001);
    chk("R9 reload write", reload_q, 32'hCAFE0001);
    cur_req = "R2";
    ticks(2);
    chk("R2 disabled hold", count_q, 32'd5);
    cyc(0, 0, 0, 1, 32'h1);
    ticks(2);
    chk("R2 decrement", count_q, 32'd3);
    repeat (3) cyc(0, 0, 0, 0, '0);
    chk("R2 no tick hold", count_q, 32'd3);

    cur_req = "R3";
    cyc(0, 0, 1, 0, 32'd2);
    cyc(0, 0, 0, 1, 32'h0F);
    chk("R8 load copies reload", count_q, 32'd2);
    chk("R8 load bit reads 0", ctrl_q, 32'h0B);
    ticks(2);
    chk("R3 no irq at zero", W'(irq), '0);
    chk("R3 reached zero", count_q, '0);
    cur_req = "R4";
    ticks(1);
    chk("R4 irq pulse", W'(irq), 1);
    chk("R4 pending set", W'(ctrl_q[4]), 1);
    cur_req = "R5";
    chk("R5 reloaded", count_q, 32'd2);
    cyc(0, 0, 0, 0, '0);
    chk("R4 single cycle", W'(irq), 0);
    ticks(6);

    cur_req = "R7";
    cyc(0, 0, 0, 1, 32'h0B);
    chk("R7 write0 keeps", W'(ctrl_q[4]), 1);
    cyc(0, 0, 0, 1, 32'h1B);
    chk("R7 write1 clears", W'(ctrl_q[4]), 0);

    cur_req = "R10";
    cyc(0, 1, 0, 0, 32'd0);
    cyc(1, 0, 1, 0, 32'd7);
    chk("R10 tick ignored at zero", count_q, '0);
    chk("R10 no irq", W'(irq), 0);
    chk("R10 no pending", W'(ctrl_q[4]), 0);
    cyc(1, 1, 0, 0, 32'd40);
    chk("R10 count write wins", count_q, 32'd40);
    cyc(1, 0, 0, 1, 32'h0B);
    chk("R10 ctrl write wins", count_q, 32'd40);

    cur_req = "R6";
    cyc(0, 0, 1, 0, 32'd1);
    cyc(0, 0, 0, 1, 32'h0D);
    ticks(2);
    chk("R6 irq one-shot", W'(irq), 1);
    chk("R6 all ones", count_q, '1);
    chk("R6 enable cleared", W'(ctrl_q[0]), 0);
    ticks(3);
    chk("R6 stopped", count_q, '1);
    chk("R7 pending persists", W'(ctrl_q[4]), 1);

    cur_req = "R8";
    cyc(0, 0, 0, 1, 32'hFFFF_FF7F);
    chk("R8 reserved zero", ctrl_q, 32'h0B);
    chk("R8 load applied", count_q, 32'd1);
    cyc(1, 1, 0, 1, 32'h0000_0004);
    chk("R8 load beats count write", count_q, 32'd1);
    ticks(4);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule